// File: doc/BRIEF.md
# SPI FIFO status and interrupt unit

This block sits between a register access port and the serial shift engine of an SPI controller. It holds the transmit and receive word FIFOs. It reports their fill levels and a compact status word, and it turns FIFO conditions into interrupt sources and DMA requests. Software, or a DMA engine, writes transmit words and reads received words through simple register accesses. The serial engine pops transmit words and pushes received words over word-level handshakes.

The FIFO depth is a build parameter, and software can find it at run time. The threshold and DMA-level registers accept only values smaller than the depth, so writing rising values and comparing the readback shows where storage stops. There are three latched error sources and two live level sources. These are presented both raw and through a mask, and the masked set is ORed onto a single interrupt line. Per-direction DMA requests compare the FIFO levels against their own programmable levels.

A 1-to-0 change of the controller enable flushes both FIFOs.

Top module: `spi_fifo_ctl`

## Requirements
- R1: The status register (index 7) holds bit 0 = engine busy, bit 1 = transmit FIFO full, bit 2 = transmit FIFO empty, bit 3 = receive FIFO empty, bit 4 = receive FIFO full. Register indices: 0 control (bit 0 enable), 1 transmit data, 2 receive data, 3 transmit threshold, 4 receive threshold, 5 transmit level, 6 receive level, 8 mask, 9 raw interrupts, 10 masked interrupts, 11 clear, 12 DMA control, 13 transmit DMA level, 14 receive DMA level.
- R2: A write to a threshold or DMA-level register is stored only when the value is below the FIFO depth, and otherwise leaves the old value in place. With the default depth of 8, writing 1 to 15 and reading back shows the first mismatch at 8.
- R3: The level registers return the current entry count of each FIFO. Both FIFOs deliver words in the order they were written.
- R4: Interrupt source bit 0 is high while the transmit level is at or below the transmit threshold. Source bit 4 is high while the receive level is above the receive threshold.
- R5: A transmit data write into a full FIFO is discarded and latches source bit 1 (transmit overflow).
- R6: A receive data read from an empty FIFO returns zero and latches source bit 2 (receive underflow).
- R7: An engine push into a full receive FIFO is discarded and latches source bit 3 (receive overflow).
- R8: Writing the clear register has these effects: bit 3 clears transmit overflow, bit 2 clears receive overflow, bit 1 clears receive underflow, and bit 0 clears all three latched sources.
- R9: The raw view shows every source whatever the mask holds. The masked view is raw AND mask, and the interrupt line is high exactly when the masked view is nonzero.
- R10: In DMA control, bit 1 enables the transmit request, which is high while the transmit level is at or below the transmit DMA level. Bit 0 enables the receive request, which is high while the receive level is above the receive DMA level.
- R11: Writing 0 to the control enable while it is 1 empties both FIFOs, and both levels read 0 afterwards. Writing 0 while it is already 0 leaves the contents in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at index 2) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from reg_addr |
| eng_enable | output | 1 | Controller enable bit to the serial engine |
| eng_busy | input | 1 | Engine busy flag reported in status |
| eng_tx_valid | output | 1 | Transmit FIFO has a word |
| eng_tx_data | output | DW | Head transmit word (zero when empty) |
| eng_tx_take | input | 1 | Engine consumes the head transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DW | Received word |
| irq | output | 1 | Interrupt line |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that the register port issues at most one access per cycle. They also assume that the engine pulses eng_tx_take and eng_rx_push for single-cycle word transfers, and that every input is steady around the rising clock edge. The bench changes inputs only on the falling edge and holds each strobe for exactly one cycle. It never raises a read and a write together, and it fills or drains a FIFO one word per access, so the overflow, underflow and flush checks meet each boundary one entry at a time.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [3:0] RA_CTRL     = 4'd0;
  localparam logic [3:0] RA_TXDATA   = 4'd1;
  localparam logic [3:0] RA_RXDATA   = 4'd2;
  localparam logic [3:0] RA_TXTHR    = 4'd3;
  localparam logic [3:0] RA_RXTHR    = 4'd4;
  localparam logic [3:0] RA_TXLVL    = 4'd5;
  localparam logic [3:0] RA_RXLVL    = 4'd6;
  localparam logic [3:0] RA_STATUS   = 4'd7;
  localparam logic [3:0] RA_IMASK    = 4'd8;
  localparam logic [3:0] RA_IRAW     = 4'd9;
  localparam logic [3:0] RA_ISTAT    = 4'd10;
  localparam logic [3:0] RA_ICLR     = 4'd11;
  localparam logic [3:0] RA_DMACTL   = 4'd12;
  localparam logic [3:0] RA_TXDMALVL = 4'd13;
  localparam logic [3:0] RA_RXDMALVL = 4'd14;

  localparam int NSRC   = 5;
  localparam int NLATCH = 3;

  // interrupt source positions (decoded by software)
  localparam int SRC_TXE   = 0;
  localparam int SRC_TXOVF = 1;
  localparam int SRC_RXUND = 2;
  localparam int SRC_RXOVF = 3;
  localparam int SRC_RXF   = 4;
endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_d  = push ? ptr_step(wr_q) : wr_q;
    rd_d  = pop  ? ptr_step(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + LW'(1);
    else if (pop && !push) cnt_d = cnt_q - LW'(1);
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign level = cnt_q;
  assign full  = (cnt_q == LW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/sfc_irq.sv
module sfc_irq
  import spi_fifo_pkg::*;
#(
  parameter int LW = 4,
  parameter int TW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LW-1:0]     tx_lvl,
  input  logic [LW-1:0]     rx_lvl,
  input  logic [TW-1:0]     tx_thr,
  input  logic [TW-1:0]     rx_thr,
  input  logic              set_txovf,
  input  logic              set_rxund,
  input  logic              set_rxovf,
  input  logic              clr_we,
  input  logic [3:0]        clr_bits,
  input  logic [NSRC-1:0]   mask,
  output logic [NSRC-1:0]   raw,
  output logic [NSRC-1:0]   masked,
  output logic              irq
);
  logic [NLATCH-1:0] set_v, clr_v, stk_q, stk_d;

  // latched source order: 0 tx overflow, 1 rx underflow, 2 rx overflow
  assign set_v = {set_rxovf, set_rxund, set_txovf};
  assign clr_v = {clr_bits[2], clr_bits[1], clr_bits[3]} | {NLATCH{clr_bits[0]}};

  for (genvar k = 0; k < NLATCH; k++) begin : g_latch
    always_comb begin
      stk_d[k] = set_v[k] | (stk_q[k] & ~(clr_we & clr_v[k]));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stk_q[k] <= 1'b0;
      else        stk_q[k] <= stk_d[k];
    end
  end

  always_comb begin
    raw            = '0;
    raw[SRC_TXE]   = (tx_lvl <= LW'(tx_thr));
    raw[SRC_TXOVF] = stk_q[0];
    raw[SRC_RXUND] = stk_q[1];
    raw[SRC_RXOVF] = stk_q[2];
    raw[SRC_RXF]   = (rx_lvl > LW'(rx_thr));
  end

  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/spi_fifo_ctl.sv
module spi_fifo_ctl
  import spi_fifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          eng_enable,
  input  logic          eng_busy,
  output logic          eng_tx_valid,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_tx_take,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  output logic          irq,
  output logic          dma_tx_req,
  output logic          dma_rx_req
);
  localparam int LW = $clog2(DEPTH+1);
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // configuration state
  logic          en_q, en_d;
  logic [TW-1:0] tx_thr_q, tx_thr_d, rx_thr_q, rx_thr_d;
  logic [TW-1:0] tx_dl_q, tx_dl_d, rx_dl_q, rx_dl_d;
  logic [NSRC-1:0] imask_q, imask_d;
  logic [1:0]    dmac_q, dmac_d;

  logic wr_cfg_ok;
  assign wr_cfg_ok = (reg_wdata < DW'(DEPTH));

  always_comb begin
    en_d     = en_q;
    tx_thr_d = tx_thr_q;
    rx_thr_d = rx_thr_q;
    tx_dl_d  = tx_dl_q;
    rx_dl_d  = rx_dl_q;
    imask_d  = imask_q;
    dmac_d   = dmac_q;
    if (reg_wr) begin
      case (reg_addr)
        RA_CTRL:     en_d    = reg_wdata[0];
        RA_IMASK:    imask_d = reg_wdata[NSRC-1:0];
        RA_DMACTL:   dmac_d  = reg_wdata[1:0];
        RA_TXTHR:    if (wr_cfg_ok) tx_thr_d = reg_wdata[TW-1:0];
        RA_RXTHR:    if (wr_cfg_ok) rx_thr_d = reg_wdata[TW-1:0];
        RA_TXDMALVL: if (wr_cfg_ok) tx_dl_d  = reg_wdata[TW-1:0];
        RA_RXDMALVL: if (wr_cfg_ok) rx_dl_d  = reg_wdata[TW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      en_q     <= 1'b0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
      tx_dl_q  <= '0;
      rx_dl_q  <= '0;
      imask_q  <= '0;
      dmac_q   <= '0;
    end else if (reg_wr) begin
      en_q     <= en_d;
      tx_thr_q <= tx_thr_d;
      rx_thr_q <= rx_thr_d;
      tx_dl_q  <= tx_dl_d;
      rx_dl_q  <= rx_dl_d;
      imask_q  <= imask_d;
      dmac_q   <= dmac_d;
    end
  end

  // FIFO traffic decode
  logic wr_tx, rd_rx, flush;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic [DW-1:0] tx_head, rx_head;

  assign wr_tx   = reg_wr && (reg_addr == RA_TXDATA);
  assign rd_rx   = reg_rd && (reg_addr == RA_RXDATA);
  assign flush   = reg_wr && (reg_addr == RA_CTRL) && !reg_wdata[0] && en_q;
  assign tx_push = wr_tx && !tx_full;
  assign tx_pop  = eng_tx_take && !tx_empty;
  assign rx_push = eng_rx_push && !rx_full;
  assign rx_pop  = rd_rx && !rx_empty;

  sfc_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_s_n), .flush(flush),
    .push(tx_push), .din(reg_wdata), .pop(tx_pop), .dout(tx_head),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  sfc_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_s_n), .flush(flush),
    .push(rx_push), .din(eng_rx_data), .pop(rx_pop), .dout(rx_head),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  // interrupt sources
  logic [NSRC-1:0] irq_raw, irq_msk;
  logic            iclr_we;
  assign iclr_we = reg_wr && (reg_addr == RA_ICLR);

  sfc_irq #(.LW(LW), .TW(TW)) u_irq (
    .clk(clk), .rst_n(rst_s_n),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_thr(tx_thr_q), .rx_thr(rx_thr_q),
    .set_txovf(wr_tx && tx_full),
    .set_rxund(rd_rx && rx_empty),
    .set_rxovf(eng_rx_push && rx_full),
    .clr_we(iclr_we), .clr_bits(reg_wdata[3:0]),
    .mask(imask_q), .raw(irq_raw), .masked(irq_msk), .irq(irq)
  );

  // status and requests
  logic [4:0] stat_vec;
  assign stat_vec   = {rx_full, rx_empty, tx_empty, tx_full, eng_busy};
  assign dma_tx_req = dmac_q[1] && (tx_lvl <= LW'(tx_dl_q));
  assign dma_rx_req = dmac_q[0] && (rx_lvl >  LW'(rx_dl_q));

  assign eng_enable   = en_q;
  assign eng_tx_valid = !tx_empty;
  assign eng_tx_data  = tx_empty ? '0 : tx_head;

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:     reg_rdata[0]        = en_q;
      RA_RXDATA:   reg_rdata           = rx_empty ? '0 : rx_head;
      RA_TXTHR:    reg_rdata[TW-1:0]   = tx_thr_q;
      RA_RXTHR:    reg_rdata[TW-1:0]   = rx_thr_q;
      RA_TXLVL:    reg_rdata[LW-1:0]   = tx_lvl;
      RA_RXLVL:    reg_rdata[LW-1:0]   = rx_lvl;
      RA_STATUS:   reg_rdata[4:0]      = stat_vec;
      RA_IMASK:    reg_rdata[NSRC-1:0] = imask_q;
      RA_IRAW:     reg_rdata[NSRC-1:0] = irq_raw;
      RA_ISTAT:    reg_rdata[NSRC-1:0] = irq_msk;
      RA_DMACTL:   reg_rdata[1:0]      = dmac_q;
      RA_TXDMALVL: reg_rdata[TW-1:0]   = tx_dl_q;
      RA_RXDMALVL: reg_rdata[TW-1:0]   = rx_dl_q;
      default:     reg_rdata           = '0;
    endcase
  end
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk
  import spi_fifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [3:0]      reg_addr,
  input logic [DW-1:0]   reg_rdata,
  input logic            eng_rx_push,
  input logic            eng_enable,
  input logic [LW-1:0]   tx_lvl,
  input logic [LW-1:0]   rx_lvl,
  input logic            tx_full,
  input logic            rx_full,
  input logic            rx_empty,
  input logic [4:0]      stat_vec,
  input logic [NSRC-1:0] irq_raw,
  input logic [NSRC-1:0] imask_q,
  input logic            irq
);
  // R3
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

  // R1
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_vec[1] && stat_vec[2]) && !(stat_vec[3] && stat_vec[4]));

  // R4
  tx_src_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl == '0) |-> irq_raw[SRC_TXE]);

  // R4
  rx_src_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl == '0) |-> !irq_raw[SRC_RXF]);

  // R5
  tx_ovf_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == RA_TXDATA) && tx_full) |=> irq_raw[SRC_TXOVF]);

  // R6
  rx_und_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == RA_RXDATA) && rx_empty) |-> (reg_rdata == '0));

  // R7
  rx_ovf_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_push && rx_full) |=> irq_raw[SRC_RXOVF]);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_raw & imask_q) == '0) |-> !irq);

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_enable) |-> (tx_lvl == '0) && (rx_lvl == '0));
endmodule

bind spi_fifo_ctl sfc_chk #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .eng_rx_push(eng_rx_push),
  .eng_enable(eng_enable), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
  .tx_full(tx_full), .rx_full(rx_full), .rx_empty(rx_empty),
  .stat_vec(stat_vec), .irq_raw(irq_raw), .imask_q(imask_q), .irq(irq)
);

// File: tb/spi_fifo_ctl_bench.sv
`timescale 1ns/1ps
module spi_fifo_ctl_bench;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam logic [3:0] A_CTRL = 0, A_TXD = 1, A_RXD = 2, A_TXT = 3, A_RXT = 4,
    A_TXL = 5, A_RXL = 6, A_ST = 7, A_MSK = 8, A_RAW = 9, A_IST = 10, A_CLR = 11,
    A_DMC = 12, A_TXDL = 13, A_RXDL = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic eng_enable, eng_busy = 1'b0, eng_tx_valid, eng_tx_take = 1'b0;
  logic [DW-1:0] eng_tx_data;
  logic eng_rx_push = 1'b0;
  logic [DW-1:0] eng_rx_data = '0;
  logic irq, dma_tx_req, dma_rx_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_fifo_ctl #(.DW(DW), .DEPTH(DEPTH)) u_spi_fifo_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_enable(eng_enable), .eng_busy(eng_busy), .eng_tx_valid(eng_tx_valid),
    .eng_tx_data(eng_tx_data), .eng_tx_take(eng_tx_take),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic eng_push(input logic [DW-1:0] d);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk); eng_rx_push = 1'b0;
  endtask

  task automatic eng_take();
    @(negedge clk); eng_tx_take = 1'b1;
    @(negedge clk); eng_tx_take = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic clean();
    wr(A_CTRL, 1); wr(A_CTRL, 0); wr(A_CLR, 1);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd(A_ST, v);  chk("R1 reset status", v, 32'h0C);
    rd(A_TXL, v); chk("R3 reset tx level", v, 0);
    rd(A_RAW, v); chk("R4 reset raw", v, 32'h01);
    settle();
    chk("R9 reset irq", irq, 0);
    chk("R10 reset dma", {dma_tx_req, dma_rx_req}, 0);
  endtask

  task automatic t_depth();
    logic [DW-1:0] v;
    int found = 0;
    for (int i = 1; i < 16; i++) begin
      wr(A_TXT, DW'(i)); rd(A_TXT, v);
      if (found == 0 && v != DW'(i)) found = i;
    end
    chk("R2 discovered depth", found, DEPTH);
    rd(A_TXT, v); chk("R2 oversize kept old", v, 7);
    wr(A_RXT, 5); wr(A_RXT, 8); rd(A_RXT, v); chk("R2 rx threshold", v, 5);
    wr(A_TXDL, 3); wr(A_TXDL, 12); rd(A_TXDL, v); chk("R2 dma level", v, 3);
    wr(A_TXT, 0); wr(A_RXT, 0); wr(A_TXDL, 0);
  endtask

  task automatic t_order();
    logic [DW-1:0] v;
    wr(A_TXD, 16'h1111); wr(A_TXD, 16'h2222); wr(A_TXD, 16'h3333);
    rd(A_TXL, v); chk("R3 tx level 3", v, 3);
    settle(); chk("R3 tx head", eng_tx_data, 16'h1111);
    eng_take(); #1 chk("R3 tx second", eng_tx_data, 16'h2222);
    rd(A_TXL, v); chk("R3 tx level 2", v, 2);
    eng_push(16'hAAAA); eng_push(16'hBBBB);
    rd(A_RXL, v); chk("R3 rx level 2", v, 2);
    rd(A_RXD, v); chk("R3 rx first", v, 16'hAAAA);
    rd(A_RXD, v); chk("R3 rx second", v, 16'hBBBB);
    rd(A_RXL, v); chk("R3 rx level 0", v, 0);
    clean();
  endtask

  task automatic t_txovf();
    logic [DW-1:0] v;
    for (int i = 0; i < 9; i++) wr(A_TXD, DW'(16'h100 + i));
    rd(A_TXL, v); chk("R5 tx level capped", v, DEPTH);
    rd(A_ST, v);  chk("R5 status tx full", v[1], 1);
    rd(A_RAW, v); chk("R5 overflow latched", v[1], 1);
    for (int i = 0; i < 7; i++) eng_take();
    settle(); chk("R5 last kept word", eng_tx_data, 16'h107);
    eng_take(); #1 chk("R5 dropped word absent", eng_tx_valid, 0);
  endtask

  task automatic t_rxund();
    logic [DW-1:0] v;
    rd(A_RXD, v); chk("R6 empty read zero", v, 0);
    rd(A_RAW, v); chk("R6 underflow latched", v[2], 1);
  endtask

  task automatic t_rxovf();
    logic [DW-1:0] v;
    for (int i = 0; i < 9; i++) eng_push(DW'(16'h200 + i));
    rd(A_RXL, v); chk("R7 rx level capped", v, DEPTH);
    rd(A_ST, v);  chk("R1 status rx full", v[4:3], 2'b10);
    rd(A_RAW, v); chk("R7 overflow latched", v[3], 1);
    for (int i = 0; i < 8; i++) rd(A_RXD, v);
    chk("R7 last kept word", v, 16'h207);
  endtask

  task automatic t_clear();
    logic [DW-1:0] v;
    rd(A_RAW, v); chk("R8 all latched", v & 16'hE, 16'hE);
    wr(A_CLR, 16'h8); rd(A_RAW, v); chk("R8 clear tx overflow", v & 16'hE, 16'hC);
    wr(A_CLR, 16'h2); rd(A_RAW, v); chk("R8 clear underflow", v & 16'hE, 16'h8);
    rd(A_RXD, v); wr(A_CLR, 16'h4); rd(A_RAW, v); chk("R8 clear rx overflow", v & 16'hE, 16'h4);
    wr(A_CLR, 16'h1); rd(A_RAW, v); chk("R8 clear all", v & 16'hE, 16'h0);
  endtask

  task automatic t_levels();
    logic [DW-1:0] v;
    wr(A_TXT, 1); wr(A_TXD, 1); wr(A_TXD, 2);
    rd(A_RAW, v); chk("R4 tx above threshold", v[0], 0);
    eng_take(); rd(A_RAW, v); chk("R4 tx at threshold", v[0], 1);
    wr(A_RXT, 2); eng_push(1); eng_push(2);
    rd(A_RAW, v); chk("R4 rx at threshold", v[4], 0);
    eng_push(3); rd(A_RAW, v); chk("R4 rx above threshold", v[4], 1);
    clean(); wr(A_TXT, 0); wr(A_RXT, 0);
  endtask

  task automatic t_mask();
    logic [DW-1:0] v;
    for (int i = 0; i < 9; i++) wr(A_TXD, DW'(i));
    wr(A_MSK, 16'h02);
    rd(A_IST, v); chk("R9 masked view", v, 16'h02);
    settle(); chk("R9 irq high", irq, 1);
    wr(A_MSK, 16'h10);
    rd(A_RAW, v); chk("R9 raw ignores mask", v, 16'h02);
    settle(); chk("R9 irq low", irq, 0);
    clean(); wr(A_MSK, 16'h01); settle(); chk("R9 tx empty irq", irq, 1);
    wr(A_MSK, 0);
  endtask

  task automatic t_dma();
    wr(A_DMC, 2); wr(A_TXDL, 1); settle();
    chk("R10 tx req at low level", dma_tx_req, 1);
    chk("R10 rx req disabled", dma_rx_req, 0);
    wr(A_TXD, 5); wr(A_TXD, 6); settle();
    chk("R10 tx req above level", dma_tx_req, 0);
    wr(A_DMC, 3); wr(A_RXDL, 0); eng_push(9); settle();
    chk("R10 rx req above level", dma_rx_req, 1);
    wr(A_DMC, 2); settle();
    chk("R10 rx req off", dma_rx_req, 0);
    wr(A_DMC, 0); clean();
  endtask

  task automatic t_flush();
    logic [DW-1:0] v;
    wr(A_TXD, 7); wr(A_CTRL, 0);
    rd(A_TXL, v); chk("R11 no flush when idle", v, 1);
    wr(A_CTRL, 1); settle(); chk("R11 enable out", eng_enable, 1);
    wr(A_TXD, 8); eng_push(4); eng_push(5);
    wr(A_CTRL, 0);
    rd(A_TXL, v); chk("R11 tx flushed", v, 0);
    rd(A_RXL, v); chk("R11 rx flushed", v, 0);
    rd(A_ST, v);  chk("R11 status empty", v, 16'h0C);
  endtask

  task automatic t_busy();
    logic [DW-1:0] v;
    eng_busy = 1'b1;
    rd(A_ST, v); chk("R1 busy bit", v, 16'h0D);
    eng_busy = 1'b0;
    rd(A_ST, v); chk("R1 busy cleared", v, 16'h0C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_depth();
    t_order();
    t_txovf();
    t_rxund();
    t_rxovf();
    t_clear();
    t_levels();
    t_mask();
    t_dma();
    t_flush();
    t_busy();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule